// File: doc/BRIEF.md
# Programmable Watchdog Timer with Two-Step Refresh

This block is a 15-bit watchdog counter for a small microcontroller-style system. A clock-enable tick feeds a selectable prescaler (divide by 2 or by 16), and each prescaler step advances the counter. Software starts the counter with a single write, but no write can stop it afterwards. To keep the system alive, software must refresh the counter in time. A refresh takes two consecutive control writes: an arm write followed directly by a kick write. The refresh loads a 7-bit reload value into the upper counter bits and clears the lower eight bits.

If the counter rolls over from its maximum value, the block raises a one-cycle reset request and halts itself. It also sets a sticky status bit. Software reads that bit after the system restarts to tell a watchdog reset from an external one. While the idle or power-down input is high, the counter and its prescaler are frozen. The synchronous active-low reset input acts as the external reset pin.

Top module: `wdog_core`

## Requirements
- R1: After `rst_n` is sampled low, every readable register reads 0x00 and `rst_req_o` is low.
- R2: A control write (address 0) with bit 1 set starts the counter. While it runs, each tick advances the prescaler, and the counter increments once every 2 ticks when bit 7 of the reload register is 0, or once every 16 ticks when it is 1.
- R3: Once running, the counter cannot be stopped by any write. The run state, read at status bit 1 of address 0, clears only on a rollover or an external reset.
- R4: A refresh happens only when a control write with bit 1 set is the very next register write after a control write with bit 0 set. A kick without a preceding arm does not load the counter, and neither does a kick that follows any other intervening write.
- R5: A refresh sets the counter to {reload[6:0], 8'h00} on the same edge and clears the prescaler phase. A refresh takes priority over a count step in the same cycle.
- R6: The arm state (status bit 0 of address 0) is set by a control write with bit 0 set. It clears on the next register write of any kind, including the kick that completes a refresh.
- R7: When the counter is at 0x7FFF and takes a step, it wraps to 0x0000. `rst_req_o` is then high for exactly one cycle, starting the cycle after that edge, and the run state clears.
- R8: A rollover sets the watchdog status bit (bit 2 of address 0). That bit stays set until an external reset clears it.
- R9: While `idle_i` or `pdown_i` is high, the counter and the prescaler keep their values.
- R10: With reload value R and a tick on every cycle, the reset request comes 256·(128−R)·2 clocks after the refresh edge at the fast rate, and 256·(128−R)·16 clocks at the slow rate. For R = 0x7F these are 512 and 4096 clocks.
- R11: Address 1 reads back {slow_select, reload[6:0]}. Address 2 reads counter bits 7:0, and address 3 reads {1'b0, counter bits 14:8}. Writes to addresses 2 and 3 change nothing except clearing the arm state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low external reset |
| tick_i | input | 1 | Count-rate clock enable feeding the prescaler |
| idle_i | input | 1 | Idle mode; freezes counting |
| pdown_i | input | 1 | Power-down mode; freezes counting |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 8 | Combinational read data |
| rst_req_o | output | 1 | One-cycle watchdog reset request |

## Verification
Most faults in the counter or the prescaler show up within one cycle: the count readback at addresses 2 and 3 drifts away from the expected step pattern. Faults in the handshake show up at the first mis-ordered write sequence. A wrongly kept arm state lets a late kick reload the counter, so the readback jumps to the reload value where it should have kept counting. A fault in the rollover path shows up only when the counter reaches its end. The reset request then arrives at the wrong clock, lasts too long, or leaves the run or status bit wrong. Directed timeouts at both prescaler rates pin that clock exactly.

// File: rtl/wdog_pkg.sv
// Package: shared constants for the watchdog block.
// Holds the register addresses and bit positions that the register
// decode and the bench both rely on.
package wdog_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    // Register addresses
    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_RELOAD = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_CNT_LO = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_CNT_HI = 2'd3;

    // Control / status bit positions (address 0)
    localparam int BIT_ARM  = 0;
    localparam int BIT_KICK = 1;
    localparam int BIT_RUN  = 1;
    localparam int BIT_WFLG = 2;

    // Reload register bit positions (address 1)
    localparam int BIT_SLOW = 7;

endpackage

// File: rtl/wdog_prescaler.sv
// Module: wdog_prescaler
// Divides the incoming tick by FAST_DIV or SLOW_DIV and emits one step
// pulse per division period.
// Assumes: FAST_DIV <= SLOW_DIV, both >= 2. The phase is held at zero
// while the timer is stopped, and is cleared by a refresh.
module wdog_prescaler #(
    parameter int FAST_DIV = 2,
    parameter int SLOW_DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic hold_i,
    input  logic tick_i,
    input  logic slow_i,
    input  logic clr_i,
    output logic step_o
);

    localparam int PW = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
    localparam logic [PW-1:0] FAST_LIM = PW'(FAST_DIV - 1);
    localparam logic [PW-1:0] SLOW_LIM = PW'(SLOW_DIV - 1);

    logic [PW-1:0] phase_q;
    logic [PW-1:0] limit;
    logic          advance;
    logic          at_end;

    // Select the terminal phase for the chosen rate.
    always_comb begin
        limit   = slow_i ? SLOW_LIM : FAST_LIM;
        advance = run_i && !hold_i && tick_i;
        at_end  = (phase_q >= limit);
        step_o  = advance && at_end;
    end

    // Advance the phase on each accepted tick, wrapping at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i || clr_i) begin
            phase_q <= '0;
        end else if (advance) begin
            phase_q <= at_end ? '0 : phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/wdog_counter.sv
// Module: wdog_counter
// The watchdog count register. A load presets the upper REL_W bits from
// the reload value and clears the lower bits. A step increments it.
// Assumes: load and step may coincide, and the load wins. The wrap flag
// is combinational and marks a step taken from the all-ones value.
module wdog_counter #(
    parameter int CNT_W = 15,
    parameter int REL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             load_i,
    input  logic [REL_W-1:0] reload_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);

    localparam int LO_W = CNT_W - REL_W;

    logic [CNT_W-1:0] cnt_q;

    // Flag the terminal step that rolls the counter back to zero.
    always_comb begin
        wrap_o = step_i && !load_i && (&cnt_q);
        cnt_o  = cnt_q;
    end

    // Load takes priority over the count step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= {reload_i, {LO_W{1'b0}}};
        end else if (step_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/wdog_regs.sv
// Module: wdog_regs
// Register decode for the watchdog. Holds the reload value, the rate
// select, the arm state of the two-write refresh, the run state and the
// sticky watchdog status bit. Also drives the combinational readback.
// Assumes: one write per cycle. wrap_i comes from the counter in the
// same cycle.
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int CNT_W = 15,
    parameter int REL_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              wrap_i,
    output logic              refresh_o,
    output logic              run_o,
    output logic              slow_o,
    output logic [REL_W-1:0]  reload_o,
    output logic              flag_o,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int LO_W = CNT_W - REL_W;

    logic             arm_q;
    logic             run_q;
    logic             flag_q;
    logic             slow_q;
    logic [REL_W-1:0] reload_q;
    logic             wr_ctrl;
    logic             wr_rel;
    logic             kick;

    // Decode the write strobes and the completed refresh handshake.
    always_comb begin
        wr_ctrl   = wr_en_i && (wr_addr_i == ADDR_CTRL);
        wr_rel    = wr_en_i && (wr_addr_i == ADDR_RELOAD);
        kick      = wr_ctrl && wr_data_i[BIT_KICK];
        refresh_o = kick && arm_q;
    end

    // Arm state: set by an arm write, cleared by any other write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q <= 1'b0;
        end else if (wr_en_i) begin
            arm_q <= wr_ctrl && wr_data_i[BIT_ARM] && !refresh_o;
        end
    end

    // Run state: set by a kick, cleared only by a rollover.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
        end else if (wrap_i) begin
            run_q <= 1'b0;
        end else if (kick) begin
            run_q <= 1'b1;
        end
    end

    // Sticky watchdog status: set by a rollover, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (wrap_i) begin
            flag_q <= 1'b1;
        end
    end

    // Reload value and rate select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
            slow_q   <= 1'b0;
        end else if (wr_rel) begin
            reload_q <= wr_data_i[REL_W-1:0];
            slow_q   <= wr_data_i[BIT_SLOW];
        end
    end

    // Readback multiplexer.
    always_comb begin
        rd_data_o = '0;
        case (rd_addr_i)
            ADDR_CTRL: begin
                rd_data_o[BIT_ARM]  = arm_q;
                rd_data_o[BIT_RUN]  = run_q;
                rd_data_o[BIT_WFLG] = flag_q;
            end
            ADDR_RELOAD: begin
                rd_data_o[REL_W-1:0] = reload_q;
                rd_data_o[BIT_SLOW]  = slow_q;
            end
            ADDR_CNT_LO: rd_data_o = DATA_W'(cnt_i[LO_W-1:0]);
            ADDR_CNT_HI: rd_data_o = DATA_W'(cnt_i[CNT_W-1:LO_W]);
            default:     rd_data_o = '0;
        endcase
    end

    assign run_o    = run_q;
    assign slow_o   = slow_q;
    assign reload_o = reload_q;
    assign flag_o   = flag_q;

endmodule

// File: rtl/wdog_core.sv
// Module: wdog_core (top)
// Programmable watchdog: a prescaler, a 15-bit counter with an upper-bit
// reload, a two-write refresh handshake, and a registered one-cycle
// reset request on rollover.
// Assumes: rst_n is the external reset, sampled synchronously. tick_i is
// a clock enable at the base count rate.
module wdog_core
    import wdog_pkg::*;
#(
    parameter int CNT_W    = 15,
    parameter int REL_W    = 7,
    parameter int FAST_DIV = 2,
    parameter int SLOW_DIV = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              idle_i,
    input  logic              pdown_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rst_req_o
);

    logic             hold;
    logic             step;
    logic             wrap;
    logic             refresh;
    logic             run;
    logic             slow;
    logic             flag;
    logic [REL_W-1:0] reload;
    logic [CNT_W-1:0] cnt;
    logic             rst_req_q;

    // Either low-power mode freezes the count path.
    assign hold = idle_i || pdown_i;

    wdog_regs #(
        .CNT_W (CNT_W),
        .REL_W (REL_W)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rd_addr_i (rd_addr_i),
        .cnt_i     (cnt),
        .wrap_i    (wrap),
        .refresh_o (refresh),
        .run_o     (run),
        .slow_o    (slow),
        .reload_o  (reload),
        .flag_o    (flag),
        .rd_data_o (rd_data_o)
    );

    wdog_prescaler #(
        .FAST_DIV (FAST_DIV),
        .SLOW_DIV (SLOW_DIV)
    ) pre_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .hold_i (hold),
        .tick_i (tick_i),
        .slow_i (slow),
        .clr_i  (refresh),
        .step_o (step)
    );

    wdog_counter #(
        .CNT_W (CNT_W),
        .REL_W (REL_W)
    ) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_i   (step),
        .load_i   (refresh),
        .reload_i (reload),
        .cnt_o    (cnt),
        .wrap_o   (wrap)
    );

    // Register the rollover into a single-cycle reset request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req_q <= 1'b0;
        end else begin
            rst_req_q <= wrap;
        end
    end

    assign rst_req_o = rst_req_q;

endmodule

// File: rtl/wdog_core_chk.sv
// Module: wdog_core_chk
// Checker bound into wdog_core. It observes the run state, the status
// bit, the counter, the reload value and the reset request.
// Assumes: all inputs are sampled on the rising clock edge.
module wdog_core_chk #(
    parameter int CNT_W = 15,
    parameter int REL_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             idle,
    input logic             pdown,
    input logic             refresh,
    input logic             run,
    input logic             flag,
    input logic             rst_req,
    input logic [CNT_W-1:0] cnt,
    input logic [REL_W-1:0] reload
);

    localparam int LO_W = CNT_W - REL_W;

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req); // R7

    AST_REQ_STOPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> !run); // R7

    AST_NO_SW_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(run) && $past(rst_n)) |-> rst_req); // R3

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        flag |=> flag); // R8

    AST_REQ_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> flag); // R8

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        ((idle || pdown) && !refresh) |=> $stable(cnt)); // R9

    AST_REFRESH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |=> (cnt == {$past(reload), {LO_W{1'b0}}})); // R5

endmodule

bind wdog_core wdog_core_chk #(
    .CNT_W (CNT_W),
    .REL_W (REL_W)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .idle    (idle_i),
    .pdown   (pdown_i),
    .refresh (refresh),
    .run     (run),
    .flag    (flag),
    .rst_req (rst_req_o),
    .cnt     (cnt),
    .reload  (reload)
);

// File: tb/wdog_core_tb_top.sv
// Bench for wdog_core: directed corner cases, then seeded random traffic.
// A bench model computes the expected registers from the requirements.
module wdog_core_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick, idle, pdown, wr_en;
    logic [1:0] wr_addr, rd_addr;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic       rst_req;

    int checks = 0;
    int errors = 0;

    // Expected state
    bit [14:0] m_cnt;
    bit        m_run, m_arm, m_flag, m_sel, m_req;
    bit [6:0]  m_rel;
    bit [3:0]  m_pre;

    always #5 clk = ~clk;

    wdog_core dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .idle_i    (idle),
        .pdown_i   (pdown),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .rst_req_o (rst_req)
    );

    // Expected next state, per the requirements
    always @(posedge clk) begin
        bit wc, kick, rf, adv, stp, wrp;
        bit [3:0] lim;
        if (!rst_n) begin
            m_cnt = '0; m_run = 0; m_arm = 0; m_flag = 0;
            m_sel = 0; m_req = 0; m_rel = '0; m_pre = '0;
        end else begin
            wc   = wr_en && (wr_addr == 2'd0);
            kick = wc && wr_data[1];
            rf   = kick && m_arm;
            lim  = m_sel ? 4'd15 : 4'd1;
            adv  = m_run && !idle && !pdown && tick;
            stp  = adv && (m_pre >= lim);
            wrp  = stp && !rf && (m_cnt == 15'h7FFF);
            m_req = wrp;
            if (!m_run || rf) m_pre = '0;
            else if (adv)     m_pre = (m_pre >= lim) ? 4'd0 : m_pre + 4'd1;
            if (rf)       m_cnt = {m_rel, 8'h00};
            else if (stp) m_cnt = m_cnt + 15'd1;
            if (wrp)       m_run = 0;
            else if (kick) m_run = 1;
            if (wr_en) m_arm = wc && wr_data[0] && !rf;
            if (wrp) m_flag = 1;
            if (wr_en && wr_addr == 2'd1) {m_sel, m_rel} = wr_data;
        end
    end

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0:    return {5'b0, m_flag, m_run, m_arm};
            2'd1:    return {m_sel, m_rel};
            2'd2:    return m_cnt[7:0];
            default: return {1'b0, m_cnt[14:8]};
        endcase
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] peek(input logic [1:0] a);
        return 8'h00 | a;
    endfunction

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    // Compare every register and the request with the model
    task automatic compare_all();
        logic [7:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            check(a == 0 ? "R3 status" : (a == 1 ? "R11 reload" : "R2 count"),
                  {8'h0, v}, {8'h0, exp_read(a[1:0])});
        end
        check("R7 request", {15'h0, rst_req}, {15'h0, m_req});
    endtask

    // One clock cycle with an optional write
    task automatic cyc(input bit we, input logic [1:0] a, input logic [7:0] d);
        wr_en = we; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        compare_all();
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) cyc(0, 2'd0, 8'h00);
    endtask

    // Count cycles from the refresh edge until the request appears
    task automatic time_to_req(output int n);
        n = 0;
        do begin
            cyc(0, 2'd0, 8'h00);
            n++;
        end while (!rst_req && n < 6000);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL R7 watchdog: actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v, held;
        int n;
        void'($urandom(32'h5EED_0042));
        rst_n = 0; tick = 1; idle = 0; pdown = 0; wr_en = 0;
        wr_addr = 0; wr_data = 0; rd_addr = 0;
        @(negedge clk);
        idle_cycles(3);
        rst_n = 1;

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            check("R1 reset read", {8'h0, v}, 16'h0);
        end
        check("R1 reset request", {15'h0, rst_req}, 16'h0);

        // R11: reload readback, fast rate
        cyc(1, 2'd1, 8'h7F);
        rd(2'd1, v); check("R11 reload readback", {8'h0, v}, 16'h007F);

        // R2: start and count at the fast rate
        cyc(1, 2'd0, 8'h02);
        idle_cycles(10);
        rd(2'd2, v); check("R2 fast count", {8'h0, v}, 16'h0005);

        // R3: a write with the kick bit clear does not stop the counter
        cyc(1, 2'd0, 8'h00);
        rd(2'd0, v); check("R3 still running", {8'h0, v & 8'h02}, 16'h0002);

        // R4: a kick without an arm does not reload
        cyc(1, 2'd0, 8'h02);
        rd(2'd3, v); check("R4 lone kick", {8'h0, v}, 16'h0000);

        // R6 and R4: an intervening write drops the arm state
        cyc(1, 2'd0, 8'h01);
        rd(2'd0, v); check("R6 armed", {8'h0, v & 8'h01}, 16'h0001);
        cyc(1, 2'd2, 8'hAA);
        rd(2'd0, v); check("R6 arm cleared", {8'h0, v & 8'h01}, 16'h0000);
        cyc(1, 2'd0, 8'h02);
        rd(2'd3, v); check("R4 late kick", {8'h0, v}, 16'h0000);

        // R5: a proper refresh loads the upper bits
        cyc(1, 2'd0, 8'h01);
        cyc(1, 2'd0, 8'h02);
        rd(2'd3, v); check("R5 load high", {8'h0, v}, 16'h007F);
        rd(2'd2, v); check("R5 load low", {8'h0, v}, 16'h0000);
        rd(2'd0, v); check("R6 arm after kick", {8'h0, v & 8'h01}, 16'h0000);

        // R9: idle and power-down both freeze the counter
        idle_cycles(3);
        rd(2'd2, held);
        idle = 1; idle_cycles(20); idle = 0;
        rd(2'd2, v); check("R9 idle hold", {8'h0, v}, {8'h0, held});
        pdown = 1; idle_cycles(20); pdown = 0;
        rd(2'd2, v); check("R9 power-down hold", {8'h0, v}, {8'h0, held});

        // R10: fast timeout, then R7 pulse and R8 status
        cyc(1, 2'd0, 8'h01);
        cyc(1, 2'd0, 8'h02);
        time_to_req(n);
        check("R10 fast timeout", n[15:0], 16'd512);
        rd(2'd0, v); check("R8 flag and R7 stopped", {8'h0, v}, 16'h0004);
        cyc(0, 2'd0, 8'h00);
        check("R7 pulse width", {15'h0, rst_req}, 16'h0);
        rd(2'd3, v); check("R7 wrapped high", {8'h0, v}, 16'h0000);

        // R10: slow timeout after a restart; R8 still set
        cyc(1, 2'd1, 8'hFF);
        cyc(1, 2'd0, 8'h02);
        cyc(1, 2'd0, 8'h01);
        cyc(1, 2'd0, 8'h02);
        time_to_req(n);
        check("R10 slow timeout", n[15:0], 16'd4096);
        rd(2'd0, v); check("R8 flag sticky", {8'h0, v & 8'h04}, 16'h0004);

        // Random traffic against the model
        cyc(1, 2'd1, 8'h7C);
        cyc(1, 2'd0, 8'h02);
        for (int i = 0; i < 8000; i++) begin
            int r;
            logic [1:0] a;
            logic [7:0] d;
            tick  = ($urandom % 4) != 0;
            idle  = ($urandom % 16) == 0;
            pdown = ($urandom % 32) == 0;
            r = $urandom % 100;
            if (r < 70) begin
                cyc(0, 2'd0, 8'h00);
            end else begin
                a = 2'($urandom % 4);
                d = 8'($urandom);
                if (a == 2'd1) d = {($urandom % 4) == 0, 4'hF, d[2:0]};
                if (a == 2'd0 && r < 90) d = {6'h0, r[0], ~r[0]};
                cyc(1, a, d);
            end
            if (($urandom % 3000) == 0) begin
                rst_n = 0; cyc(0, 2'd0, 8'h00); rst_n = 1;
                cyc(1, 2'd0, 8'h02);
            end
        end
        tick = 1; idle = 0; pdown = 0;

        // R8: an external reset clears the status bit
        rst_n = 0; cyc(0, 2'd0, 8'h00); rst_n = 1;
        rd(2'd0, v); check("R8 cleared by reset", {8'h0, v}, 16'h0000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule